// File: doc/BRIEF.md
# Program Interrupt Entry Sequencer

This block enters a processor's program-interrupt handler after an exception has already been detected elsewhere. It takes one request carrying an interruption code, an instruction length that is either given explicitly or marked automatic, and the current program status word (PSW) mask and address. From these it works out the instruction length and whether the saved address is advanced past the faulting instruction. It then writes the old-state words to a fixed save area through a request/acknowledge memory port, reads the new PSW mask and address from that area, and presents them for loading.

A supervisor-call request takes a shorter path that shares the same store and swap machinery. If a monitoring event is pending, the event is folded into the stored code, and the event words are saved ahead of the other words. After a supervisor call with an event pending, a program interrupt for the event alone follows straight away. The block also merges an 8-bit data- or vector-exception code into the floating-point control register value when the request calls for it.

Top module: `pgm_irq_seq`

## Requirements
- R1: The length is 2, 4 or 6 bytes. `req_len_sel` 1, 2 and 3 select 2, 4 and 6. With `req_len_sel` 0 (automatic), opcode bits [7:6] of 00 give 2, 01 and 10 give 4, and 11 gives 6. The length is stored zero-extended in the length word.
- R2: On a program request with `req_ifetch` set, the stored length is 2 whatever `req_len_sel` and the opcode say.
- R3: The stored old address is the current address plus the length for the completing codes 0x01, 0x02 and 0x04 to 0x0E. For every other code apart from 0x0080 it is the current address unchanged.
- R4: For code 0x0080 (monitoring event only), the address is advanced when `evt_nullify` is 0 and left unchanged when `evt_nullify` is 1.
- R5: When `evt_pend` is set on a program request, the stored code is the request code ORed with 0x0080. The event address and event code words are written before the length word. `evt_clear` pulses for one cycle on the acknowledge of the event-code write.
- R6: The program path writes, in this order: event address (offset 0x10) and event code (0x18) if an event is pending, then length (0x00), code (0x08), old mask (0x20), old address (0x28) and breaking-event address (0x30). Each offset is relative to `BASE`.
- R7: After the stores, the new mask is read at 0x38 and then the new address at 0x40. `psw_load` pulses in the cycle after the acknowledge of the address read, with `new_mask` and `new_addr` holding the read data.
- R8: A supervisor call writes the code (0x48), the length (0x50), the old mask (0x58) and the current address plus the length (0x60). It then reads the new mask (0x68) and the new address (0x70) and pulses `psw_load`.
- R9: A supervisor call with an event pending is followed at once by a program sequence with code 0x0080 and the call's length. That sequence uses the call's new PSW as the old PSW, and its address is advanced unless `evt_nullify` is set.
- R10: On a program request, `req_dx_kind` 1 (data) writes `req_dxc` into `fpc_out` bits [15:8], with the other bits taken from `fpc_in`, only when `afp_en` is 1. Kind 2 (vector) always writes. Kinds 0 and 3 never write. `fpc_we` pulses in the cycle after acceptance.
- R11: `busy` is 0 after reset. It rises in the cycle after a request is accepted and falls together with the final `psw_load`. A request raised while busy is ignored.
- R12: Once `mem_req` is raised, it stays high with the address, direction and write data unchanged until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe; accepted when not busy |
| req_svc | input | 1 | 1 = supervisor call, 0 = program exception |
| req_code | input | 16 | Interruption code |
| req_len_sel | input | 2 | 0 automatic, 1/2/3 = 2/4/6 bytes |
| req_opcode | input | 8 | First opcode byte at the current address |
| req_ifetch | input | 1 | Fault occurred on instruction fetch |
| req_dx_kind | input | 2 | 0 none, 1 data, 2 vector, 3 none |
| req_dxc | input | 8 | Data/vector exception code |
| afp_en | input | 1 | Additional floating-point control enabled |
| fpc_in | input | 32 | Current floating-point control value |
| cur_mask | input | DW | Current PSW mask |
| cur_addr | input | DW | Current PSW address |
| last_break_addr | input | DW | Last breaking-event address |
| evt_pend | input | 1 | Monitoring event pending |
| evt_nullify | input | 1 | Event nullifies the instruction |
| evt_code | input | 16 | Event code word |
| evt_addr | input | DW | Event address word |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | MAW | Save-area word address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | DW | Read data, valid with acknowledge |
| busy | output | 1 | Sequence in progress |
| psw_load | output | 1 | New PSW valid pulse |
| new_mask | output | DW | New PSW mask |
| new_addr | output | DW | New PSW address |
| evt_clear | output | 1 | Pending event consumed |
| fpc_we | output | 1 | Floating-point control write pulse |
| fpc_out | output | 32 | Merged floating-point control value |

## Verification
The hardest case to reach is the chained path. It needs a supervisor call with an event pending, and the event sequence must then use the call's freshly read PSW as its old state, with the advance decided by the nullify flag alone. The stimulus runs this case directly with both nullify settings and also draws it at random among the other request kinds. The memory model acknowledges after random delays, so requests are held across stalls, and requests are poked while busy to show that they are dropped.

// File: rtl/pgm_seq_pkg.sv
package pgm_seq_pkg;

  // State value equals the save-slot index; the word offset is index * 8.
  typedef enum logic [3:0] {
    SL_PLEN   = 4'd0,
    SL_PCODE  = 4'd1,
    SL_EVADDR = 4'd2,
    SL_EVCODE = 4'd3,
    SL_POMASK = 4'd4,
    SL_POADDR = 4'd5,
    SL_BEA    = 4'd6,
    SL_PNMASK = 4'd7,
    SL_PNADDR = 4'd8,
    SL_SCODE  = 4'd9,
    SL_SLEN   = 4'd10,
    SL_SOMASK = 4'd11,
    SL_SOADDR = 4'd12,
    SL_SNMASK = 4'd13,
    SL_SNADDR = 4'd14,
    SL_IDLE   = 4'd15
  } seq_st_e;

  localparam logic [15:0] EVT_BIT = 16'h0080;

  function automatic logic [2:0] opcode_len(input logic [7:0] op);
    case (op[7:6])
      2'b00:   return 3'd2;
      2'b11:   return 3'd6;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic code_completes(input logic [15:0] code);
    case (code)
      16'h0001, 16'h0002, 16'h0004, 16'h0005, 16'h0006, 16'h0007,
      16'h0008, 16'h0009, 16'h000A, 16'h000B, 16'h000C, 16'h000D,
      16'h000E: return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic addr_advances(input logic [15:0] code, input logic nullify);
    if (code == EVT_BIT) return !nullify;
    return code_completes(code);
  endfunction

endpackage

// File: rtl/pgm_len_decode.sv
module pgm_len_decode
  import pgm_seq_pkg::*;
(
  input  logic [1:0] len_sel,
  input  logic [7:0] opcode,
  input  logic       ifetch,
  input  logic       is_svc,
  output logic [2:0] ilen
);
  always_comb begin
    if (!is_svc && ifetch) ilen = 3'd2;
    else begin
      case (len_sel)
        2'd1:    ilen = 3'd2;
        2'd2:    ilen = 3'd4;
        2'd3:    ilen = 3'd6;
        default: ilen = opcode_len(opcode);
      endcase
    end
  end
endmodule

// File: rtl/pgm_fpc_merge.sv
module pgm_fpc_merge (
  input  logic [31:0] fpc_in,
  input  logic [1:0]  dx_kind,
  input  logic        afp_en,
  input  logic [7:0]  dxc,
  output logic        wr,
  output logic [31:0] fpc_new
);
  always_comb begin
    wr      = (dx_kind == 2'd2) || ((dx_kind == 2'd1) && afp_en);
    fpc_new = {fpc_in[31:16], dxc, fpc_in[7:0]};
  end
endmodule

// File: rtl/pgm_seq_fsm.sv
module pgm_seq_fsm
  import pgm_seq_pkg::*;
#(
  parameter int DW   = 64,
  parameter int MAW  = 16,
  parameter int unsigned BASE = 256
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic           req_svc,
  input  logic [15:0]    req_code,
  input  logic [2:0]     ilen,
  input  logic [DW-1:0]  cur_mask,
  input  logic [DW-1:0]  cur_addr,
  input  logic [DW-1:0]  bea,
  input  logic           evt_pend,
  input  logic           evt_nullify,
  input  logic [15:0]    evt_code,
  input  logic [DW-1:0]  evt_addr,
  output logic           mem_req,
  output logic           mem_we,
  output logic [MAW-1:0] mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_ack,
  input  logic [DW-1:0]  mem_rdata,
  output logic           busy,
  output logic           psw_load,
  output logic [DW-1:0]  new_mask,
  output logic [DW-1:0]  new_addr,
  output logic           evt_clear
);
  seq_st_e st, nxt;
  logic          evp_q, evn_q, load_q;
  logic [15:0]   code_q, evc_q;
  logic [2:0]    len_q;
  logic [DW-1:0] mask_q, addr_q, eva_q, bea_q, nmask_q, naddr_q;
  logic          step, adv;

  assign step      = (st != SL_IDLE) && mem_ack;
  assign adv       = addr_advances(code_q, evn_q);
  assign busy      = (st != SL_IDLE);
  assign mem_req   = busy;
  assign mem_we    = busy && !(st inside {SL_PNMASK, SL_PNADDR, SL_SNMASK, SL_SNADDR});
  assign mem_addr  = MAW'(BASE) + MAW'({st, 3'b000});
  assign evt_clear = (st == SL_EVCODE) && mem_ack;
  assign psw_load  = load_q;
  assign new_mask  = nmask_q;
  assign new_addr  = naddr_q;

  always_comb begin
    case (st)
      SL_EVADDR: nxt = SL_EVCODE;
      SL_EVCODE: nxt = SL_PLEN;
      SL_PLEN:   nxt = SL_PCODE;
      SL_PCODE:  nxt = SL_POMASK;
      SL_POMASK: nxt = SL_POADDR;
      SL_POADDR: nxt = SL_BEA;
      SL_BEA:    nxt = SL_PNMASK;
      SL_PNMASK: nxt = SL_PNADDR;
      SL_SCODE:  nxt = SL_SLEN;
      SL_SLEN:   nxt = SL_SOMASK;
      SL_SOMASK: nxt = SL_SOADDR;
      SL_SOADDR: nxt = SL_SNMASK;
      SL_SNMASK: nxt = SL_SNADDR;
      SL_SNADDR: nxt = evp_q ? SL_EVADDR : SL_IDLE;
      default:   nxt = SL_IDLE;
    endcase
  end

  always_comb begin
    case (st)
      SL_PLEN, SL_SLEN:     mem_wdata = DW'(len_q);
      SL_PCODE:             mem_wdata = DW'(code_q | (evp_q ? EVT_BIT : 16'h0000));
      SL_SCODE:             mem_wdata = DW'(code_q);
      SL_EVADDR:            mem_wdata = eva_q;
      SL_EVCODE:            mem_wdata = DW'(evc_q);
      SL_POMASK, SL_SOMASK: mem_wdata = mask_q;
      SL_POADDR:            mem_wdata = addr_q + (adv ? DW'(len_q) : '0);
      SL_SOADDR:            mem_wdata = addr_q + DW'(len_q);
      SL_BEA:               mem_wdata = bea_q;
      default:              mem_wdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= SL_IDLE; load_q <= 1'b0; evp_q <= 1'b0; evn_q <= 1'b0;
      code_q <= '0; evc_q <= '0; len_q <= 3'd2;
      mask_q <= '0; addr_q <= '0; eva_q <= '0; bea_q <= '0;
      nmask_q <= '0; naddr_q <= '0;
    end else begin
      load_q <= 1'b0;
      if (accept) begin
        st     <= req_svc ? SL_SCODE : (evt_pend ? SL_EVADDR : SL_PLEN);
        code_q <= req_code;  len_q  <= ilen;
        mask_q <= cur_mask;  addr_q <= cur_addr; bea_q <= bea;
        evp_q  <= evt_pend;  evn_q  <= evt_nullify;
        evc_q  <= evt_code;  eva_q  <= evt_addr;
      end else if (step) begin
        st <= nxt;
        if (st == SL_PNMASK || st == SL_SNMASK) nmask_q <= mem_rdata;
        if (st == SL_PNADDR || st == SL_SNADDR) begin
          naddr_q <= mem_rdata;
          load_q  <= 1'b1;
        end
        if (st == SL_SNADDR) begin
          code_q <= EVT_BIT;
          mask_q <= nmask_q;
          addr_q <= mem_rdata;
        end
      end
    end
  end

  p_len_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (len_q == 3'd2 || len_q == 3'd4 || len_q == 3'd6));
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  p_clear_then_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_clear |=> (st == SL_PLEN));
  p_busy_ends_with_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> psw_load);
  p_chain_after_call_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (psw_load && busy) |-> (st == SL_EVADDR));
endmodule

// File: rtl/pgm_irq_seq.sv
module pgm_irq_seq #(
  parameter int DW   = 64,
  parameter int MAW  = 16,
  parameter int unsigned BASE = 256
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           req_svc,
  input  logic [15:0]    req_code,
  input  logic [1:0]     req_len_sel,
  input  logic [7:0]     req_opcode,
  input  logic           req_ifetch,
  input  logic [1:0]     req_dx_kind,
  input  logic [7:0]     req_dxc,
  input  logic           afp_en,
  input  logic [31:0]    fpc_in,
  input  logic [DW-1:0]  cur_mask,
  input  logic [DW-1:0]  cur_addr,
  input  logic [DW-1:0]  last_break_addr,
  input  logic           evt_pend,
  input  logic           evt_nullify,
  input  logic [15:0]    evt_code,
  input  logic [DW-1:0]  evt_addr,
  output logic           mem_req,
  output logic           mem_we,
  output logic [MAW-1:0] mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_ack,
  input  logic [DW-1:0]  mem_rdata,
  output logic           busy,
  output logic           psw_load,
  output logic [DW-1:0]  new_mask,
  output logic [DW-1:0]  new_addr,
  output logic           evt_clear,
  output logic           fpc_we,
  output logic [31:0]    fpc_out
);
  logic       accept, fpc_wr;
  logic [2:0] ilen;
  logic [31:0] fpc_new;

  assign accept = req_valid && !busy;

  pgm_len_decode u_len (
    .len_sel(req_len_sel), .opcode(req_opcode), .ifetch(req_ifetch),
    .is_svc(req_svc), .ilen(ilen)
  );

  pgm_fpc_merge u_fpc (
    .fpc_in(fpc_in), .dx_kind(req_dx_kind), .afp_en(afp_en), .dxc(req_dxc),
    .wr(fpc_wr), .fpc_new(fpc_new)
  );

  pgm_seq_fsm #(.DW(DW), .MAW(MAW), .BASE(BASE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_svc(req_svc),
    .req_code(req_code), .ilen(ilen), .cur_mask(cur_mask), .cur_addr(cur_addr),
    .bea(last_break_addr), .evt_pend(evt_pend), .evt_nullify(evt_nullify),
    .evt_code(evt_code), .evt_addr(evt_addr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .busy(busy), .psw_load(psw_load), .new_mask(new_mask),
    .new_addr(new_addr), .evt_clear(evt_clear)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fpc_we  <= 1'b0;
      fpc_out <= '0;
    end else begin
      fpc_we <= accept && !req_svc && fpc_wr;
      if (accept && !req_svc && fpc_wr) fpc_out <= fpc_new;
    end
  end

  p_fpc_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fpc_we |-> $past(accept && !req_svc));
  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
endmodule

// File: tb/pgm_irq_seq_test.sv
module pgm_irq_seq_test;
  localparam int DW = 64, MAW = 16;
  localparam int unsigned BASE = 256;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_svc = 0, req_ifetch = 0, afp_en = 0;
  logic [15:0] req_code = 0, evt_code = 0;
  logic [1:0] req_len_sel = 0, req_dx_kind = 0;
  logic [7:0] req_opcode = 0, req_dxc = 0;
  logic [31:0] fpc_in = 0;
  logic [DW-1:0] cur_mask = 0, cur_addr = 0, last_break_addr = 0, evt_addr = 0;
  logic evt_pend = 0, evt_nullify = 0;
  logic mem_req, mem_we, mem_ack, busy, psw_load, evt_clear, fpc_we;
  logic [MAW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, new_mask, new_addr;
  logic [31:0] fpc_out;

  always #4 clk = ~clk;

  pgm_irq_seq #(.DW(DW), .MAW(MAW), .BASE(BASE)) uut (.*);

  function automatic logic [DW-1:0] rd_fn(input logic [MAW-1:0] a);
    return {16'hF00D, 32'h1234_5678, a};
  endfunction
  assign mem_rdata = rd_fn(mem_addr);

  function automatic logic [MAW-1:0] sa(input int s);
    return MAW'(BASE + s * 8);
  endfunction

  int tests = 0, fails = 0, cyc = 0;
  logic clr = 0;
  logic [MAW-1:0] lg_addr [0:63];
  logic [DW-1:0]  lg_data [0:63];
  logic           lg_we   [0:63];
  int lg_n = 0, ld_n = 0, evc_n = 0, evc_pos = 0, fpc_n = 0, viol = 0;
  logic [DW-1:0] ld_mask = 0, ld_addr = 0;
  logic [31:0] fpc_val = 0;
  logic prv_pend = 0;
  logic [MAW-1:0] prv_addr = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      mem_ack <= mem_req && !mem_ack && (($urandom % 3) != 0);
      prv_pend <= mem_req && !mem_ack;
      prv_addr <= mem_addr;
      if (prv_pend && (!mem_req || mem_addr != prv_addr)) viol <= viol + 1;
      if (clr) begin
        lg_n <= 0; ld_n <= 0; evc_n <= 0; fpc_n <= 0;
      end else begin
        if (mem_ack && lg_n < 64) begin
          lg_addr[lg_n] <= mem_addr; lg_data[lg_n] <= mem_wdata;
          lg_we[lg_n] <= mem_we; lg_n <= lg_n + 1;
        end
        if (psw_load) begin ld_n <= ld_n + 1; ld_mask <= new_mask; ld_addr <= new_addr; end
        if (evt_clear) begin evc_n <= evc_n + 1; evc_pos <= lg_n; end
        if (fpc_we) begin fpc_n <= fpc_n + 1; fpc_val <= fpc_out; end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected model
  logic [MAW-1:0] ex_addr [0:31];
  logic [DW-1:0]  ex_data [0:31];
  logic           ex_we   [0:31];
  string          ex_tag  [0:31];
  int ex_n, ex_evc;

  task automatic push(input bit we, input int s, input logic [DW-1:0] d, input string tag);
    ex_we[ex_n] = we; ex_addr[ex_n] = sa(s); ex_data[ex_n] = d; ex_tag[ex_n] = tag;
    ex_n++;
  endtask

  function automatic int e_len(input bit svc, input bit ifetch, input int sel, input logic [7:0] op);
    if (!svc && ifetch) return 2;
    if (sel != 0) return 2 * sel;
    if (op[7] == op[6]) return op[7] ? 6 : 2;
    return 4;
  endfunction

  function automatic bit e_adv(input logic [15:0] code, input bit nul);
    logic [15:0] cmask = 16'h7FF6;
    if (code == 16'h0080) return !nul;
    if (code < 16) return cmask[code[3:0]];
    return 0;
  endfunction

  task automatic ex_prog(input logic [15:0] code, input int len, input logic [DW-1:0] m,
                         input logic [DW-1:0] a, input bit evp, input bit nul, input string t);
    string lt, at;
    lt = (t != "") ? t : (req_ifetch ? "R2 length" : "R1 length");
    at = (t != "") ? t : ((code == 16'h0080) ? "R4 old address" : "R3 old address");
    if (evp) begin
      push(1, 2, evt_addr, (t != "") ? t : "R5 event address");
      ex_evc = ex_n;
      push(1, 3, DW'(evt_code), (t != "") ? t : "R5 event code");
    end
    push(1, 0, DW'(len), lt);
    push(1, 1, DW'(code | (evp ? 16'h0080 : 16'h0)), (t != "") ? t : "R5 code word");
    push(1, 4, m, (t != "") ? t : "R6 old mask");
    push(1, 5, a + (e_adv(code, nul) ? DW'(len) : '0), at);
    push(1, 6, last_break_addr, (t != "") ? t : "R6 break address");
    push(0, 7, 0, (t != "") ? t : "R7 new mask read");
    push(0, 8, 0, (t != "") ? t : "R7 new address read");
  endtask

  task automatic run(input bit svc, input logic [15:0] code, input int sel, input logic [7:0] op,
                     input bit ifetch, input bit evp, input bit nul, input int dxk,
                     input logic [7:0] dxc, input bit afp, input bit poke);
    int len, exp_ld;
    bit fw;
    logic [DW-1:0] em, ea;
    @(negedge clk);
    clr = 1;
    req_svc = svc; req_code = code; req_len_sel = 2'(sel); req_opcode = op; req_ifetch = ifetch;
    evt_pend = evp; evt_nullify = nul; req_dx_kind = 2'(dxk); req_dxc = dxc; afp_en = afp;
    cur_mask = {$urandom, $urandom}; cur_addr = {$urandom, $urandom};
    last_break_addr = {$urandom, $urandom}; evt_addr = {$urandom, $urandom};
    evt_code = 16'($urandom); fpc_in = $urandom;
    @(negedge clk);
    clr = 0;
    ex_n = 0; ex_evc = -1;
    len = e_len(svc, ifetch, sel, op);
    if (svc) begin
      push(1, 9, DW'(code), "R8 call code");
      push(1, 10, DW'(len), "R8 call length");
      push(1, 11, cur_mask, "R8 call old mask");
      push(1, 12, cur_addr + DW'(len), "R8 call old address");
      push(0, 13, 0, "R8 call new mask read");
      push(0, 14, 0, "R8 call new address read");
      if (evp) ex_prog(16'h0080, len, rd_fn(sa(13)), rd_fn(sa(14)), 1, nul, "R9 chained event");
    end else ex_prog(code, len, cur_mask, cur_addr, evp, nul, "");
    em = (svc && !evp) ? rd_fn(sa(13)) : rd_fn(sa(7));
    ea = (svc && !evp) ? rd_fn(sa(14)) : rd_fn(sa(8));
    exp_ld = (svc && evp) ? 2 : 1;
    fw = !svc && (dxk == 2 || (dxk == 1 && afp));
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(busy === 1'b1, "R11 busy after accept", 64'(busy), 1);
    if (poke) begin
      req_svc = 0; req_code = 16'h0001; evt_pend = 0; req_valid = 1;
      @(negedge clk);
      req_valid = 0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(lg_n == ex_n, poke ? "R11 entry count with poke" : "R6 entry count", 64'(lg_n), 64'(ex_n));
    for (int i = 0; i < ex_n && i < 32; i++)
      chk(lg_addr[i] === ex_addr[i] && lg_we[i] === ex_we[i] &&
          (!ex_we[i] || lg_data[i] === ex_data[i]), ex_tag[i],
          ex_we[i] ? lg_data[i] : 64'(lg_addr[i]), ex_we[i] ? ex_data[i] : 64'(ex_addr[i]));
    chk(ld_n == exp_ld, svc ? "R9 load count" : "R11 load count", 64'(ld_n), 64'(exp_ld));
    chk(ld_mask === em && ld_addr === ea, "R7 loaded PSW", ld_addr, ea);
    chk(evc_n == (evp ? 1 : 0) && (!evp || evc_pos == ex_evc), "R5 event clear",
        64'(evc_n), 64'(evp));
    chk(fpc_n == (fw ? 1 : 0) && (!fw || fpc_val === ((fpc_in & 32'hFFFF00FF) | (32'(dxc) << 8))),
        "R10 fpc update", {32'(fpc_n), fpc_val}, {32'(fw), (fpc_in & 32'hFFFF00FF) | (32'(dxc) << 8)});
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 0 && mem_req === 0 && psw_load === 0 && fpc_we === 0, "R11 reset state",
        {61'b0, busy, mem_req, psw_load}, 0);
    // directed corners
    run(0, 16'h0001, 0, 8'h05, 0, 0, 0, 0, 0, 0, 0);   // R1 auto 2
    run(0, 16'h0004, 0, 8'h47, 0, 0, 0, 0, 0, 0, 0);   // R1 auto 4
    run(0, 16'h0006, 0, 8'h9A, 0, 0, 0, 0, 0, 0, 0);   // R1 auto 4
    run(0, 16'h000E, 0, 8'hE3, 0, 0, 0, 0, 0, 0, 0);   // R1 auto 6
    run(0, 16'h0011, 3, 8'h00, 0, 0, 0, 0, 0, 0, 0);   // R3 nullifying
    run(0, 16'h0010, 3, 8'hFF, 1, 0, 0, 0, 0, 0, 0);   // R2 fetch fault
    run(0, 16'h0080, 2, 8'h00, 0, 1, 0, 0, 0, 0, 0);   // R4 advance
    run(0, 16'h0080, 2, 8'h00, 0, 1, 1, 0, 0, 0, 0);   // R4 nullify
    run(0, 16'h0007, 1, 8'h00, 0, 1, 0, 1, 8'hA5, 1, 0); // R5 R10 data with afp
    run(0, 16'h0007, 1, 8'h00, 0, 0, 0, 1, 8'h3C, 0, 0); // R10 data without afp
    run(0, 16'h001B, 2, 8'h00, 0, 0, 0, 2, 8'h5A, 0, 1); // R10 vector, R11 poke
    run(1, 16'h0033, 2, 8'h00, 0, 0, 0, 0, 0, 0, 0);   // R8
    run(1, 16'h0044, 0, 8'hC1, 1, 1, 0, 0, 0, 0, 0);   // R9 advance
    run(1, 16'h0055, 3, 8'h00, 0, 1, 1, 1, 8'h11, 1, 1); // R9 nullify
    for (int k = 0; k < 60; k++) begin
      logic [15:0] c;
      c = ($urandom % 4 == 0) ? 16'h0080 : 16'($urandom % 20);
      run($urandom % 3 == 0, c, int'($urandom % 4), 8'($urandom), $urandom % 4 == 0,
          $urandom % 2 == 0, $urandom % 2 == 0, int'($urandom % 4), 8'($urandom),
          $urandom % 2 == 0, $urandom % 5 == 0);
    end
    chk(viol == 0, "R12 request held until ack", 64'(viol), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule